// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional branch should be taken. Each cycle it may accept a 4-bit condition code together with the four integer flags: negative (N), zero (Z), overflow (V) and carry (C). One clock later it presents a registered taken decision, and a valid strobe marks the cycle in which that decision belongs to a request.

The sixteen codes come in pairs. The low three bits of the code pick one of eight base tests. Bit 3 inverts the result of that test. This gives never/always, equal/not-equal, the signed orderings, the unsigned orderings, the sign tests, and the carry and overflow tests. The unsigned-lower test and the carry-set test are the same function of the flags, so they share one code.

The block does not compute branch targets and does not produce flags. Those come from neighbouring logic.

Top module: `branch_cond_eval`

## Requirements
- R1: While reset is high, and in the first cycle after it, `res_valid` and `res_taken` are both 0.
- R2: Code 0 is never taken, whatever the flags. Code 8 is always taken, whatever the flags.
- R3: Code 1 is taken when Z=1. Code 9 is taken when Z=0.
- R4: Signed orderings. Code 3 (less) is taken on N^V. Code 2 (less-or-equal) is taken on Z|(N^V). Code 11 (greater-or-equal) is taken on !(N^V). Code 10 (greater) is taken on !(Z|(N^V)).
- R5: Unsigned orderings. Code 5 (lower, which is also carry-set) is taken on C. Code 4 (lower-or-same) is taken on C|Z. Code 13 (higher-or-same, which is also carry-clear) is taken on !C. Code 12 (higher) is taken on !(C|Z).
- R6: Code 6 is taken when N=1 (negative). Code 14 is taken when N=0 (positive).
- R7: Code 7 is taken when V=1. Code 15 is taken when V=0.
- R8: For every flag pattern and every k in 0..7, the decision for code k+8 is the complement of the decision for code k.
- R9: A request with `req_valid`=1 at a rising edge makes `res_valid` 1 after that edge. `res_taken` then holds the decision for that request's code and flags.
- R10: A cycle with `req_valid`=0 makes `res_valid` 0 after the edge and leaves `res_taken` unchanged, whatever the code and flag inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | A request is present this cycle |
| req_code | input | 4 | Condition code: bits 2:0 pick the base test, bit 3 inverts it |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| res_valid | output | 1 | Decision is valid this cycle |
| res_taken | output | 1 | Registered branch decision |

## Verification
The bench sweeps all 256 pairs of code and flag pattern. It derives each expected decision from the flag equations, so the cases where Z and the N^V term disagree expose a design that dropped Z from the less-or-equal and greater tests. The same sweep exposes a design that swapped the signed and unsigned groups, or that tested N where N^V is required (the cases with V=1). A per-pattern comparison of each code against its partner k+8 catches an inversion bit that is ignored, or applied to the wrong code. Idle cycles driven with changing codes and flags catch a decision register that loads without a request.

// File: rtl/bce_pkg.sv
package bce_pkg;

    localparam int CODE_W = 4;
    localparam int SEL_W  = CODE_W - 1;
    localparam int BASE_N = 1 << SEL_W;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } bce_flags_t;

    typedef enum logic [SEL_W-1:0] {
        BASE_NEVER = 3'd0,
        BASE_EQ    = 3'd1,
        BASE_SLE   = 3'd2,
        BASE_SLT   = 3'd3,
        BASE_ULE   = 3'd4,
        BASE_ULT   = 3'd5,
        BASE_NEG   = 3'd6,
        BASE_OVF   = 3'd7
    } bce_base_e;

    typedef struct packed {
        logic      invert;
        bce_base_e base;
    } bce_code_t;

    function automatic bce_code_t bce_split(input logic [CODE_W-1:0] raw);
        bce_code_t r;
        r.invert = raw[CODE_W-1];
        r.base   = bce_base_e'(raw[SEL_W-1:0]);
        return r;
    endfunction

endpackage

// File: rtl/bce_terms.sv
module bce_terms
    import bce_pkg::*;
(
    input  bce_flags_t        flags,
    output logic [BASE_N-1:0] terms
);
    logic signed_lt;

    always_comb begin
        signed_lt = flags.n ^ flags.v;
        terms = '0;
        terms[BASE_NEVER] = 1'b0;
        terms[BASE_EQ]    = flags.z;
        terms[BASE_SLE]   = flags.z | signed_lt;
        terms[BASE_SLT]   = signed_lt;
        terms[BASE_ULE]   = flags.c | flags.z;
        terms[BASE_ULT]   = flags.c;
        terms[BASE_NEG]   = flags.n;
        terms[BASE_OVF]   = flags.v;
    end
endmodule

// File: rtl/bce_select.sv
module bce_select
    import bce_pkg::*;
(
    input  bce_code_t         code,
    input  logic [BASE_N-1:0] terms,
    output logic              decision
);
    logic [BASE_N-1:0] hit;

    for (genvar g = 0; g < BASE_N; g++) begin : g_pick
        assign hit[g] = (code.base == bce_base_e'(g)) & terms[g];
    end

    assign decision = (|hit) ^ code.invert;
endmodule

// File: rtl/bce_stage.sv
module bce_stage (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic in_taken,
    output logic out_valid,
    output logic out_taken
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_taken <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_taken <= in_taken;
        end
    end

    assert_reset_R1: assert property (@(posedge clk) rst |=> (!out_valid && !out_taken));
    assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_taken)));
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
    import bce_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [CODE_W-1:0] req_code,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_v,
    input  logic              flag_c,
    output logic              res_valid,
    output logic              res_taken
);
    bce_flags_t        flags;
    bce_code_t         code;
    logic [BASE_N-1:0] terms;
    logic              decision;

    assign flags = '{n: flag_n, z: flag_z, v: flag_v, c: flag_c};
    assign code  = bce_split(req_code);

    bce_terms  u_terms  (.flags(flags), .terms(terms));
    bce_select u_select (.code(code), .terms(terms), .decision(decision));
    bce_stage  u_stage  (.clk(clk), .rst(rst), .in_valid(req_valid), .in_taken(decision),
                         .out_valid(res_valid), .out_taken(res_taken));

    assert_never_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd0) |=> !res_taken);
    assert_always_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd8) |=> res_taken);
    assert_equal_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd1) |=> (res_taken == $past(flag_z)));
    assert_notequal_R3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd9) |=> (res_taken != $past(flag_z)));
    assert_carry_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd5) |=> (res_taken == $past(flag_c)));
    assert_negative_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd6) |=> (res_taken == $past(flag_n)));
    assert_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_code == 4'd15) |=> (res_taken != $past(flag_v)));
endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic [3:0] req_code;
    logic       fn, fz, fv, fc;
    logic       res_valid, res_taken;

    int total = 0;
    int bad   = 0;
    logic got [16][16];

    always #10 clk = ~clk;

    branch_cond_eval i_branch_cond_eval (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_code(req_code),
        .flag_n(fn), .flag_z(fz), .flag_v(fv), .flag_c(fc),
        .res_valid(res_valid), .res_taken(res_taken));

    function automatic logic model(input int code, input logic n, input logic z,
                                   input logic v, input logic c);
        case (code)
            0:  return 1'b0;
            8:  return 1'b1;
            1:  return z;
            9:  return !z;
            3:  return n != v;
            2:  return z || (n != v);
            11: return n == v;
            10: return !z && (n == v);
            5:  return c;
            4:  return c || z;
            13: return !c;
            12: return !c && !z;
            6:  return n;
            14: return !n;
            7:  return v;
            default: return !v;
        endcase
    endfunction

    function automatic string req_of(input int code);
        case (code)
            0, 8:           return "R2";
            1, 9:           return "R3";
            2, 3, 10, 11:   return "R4";
            4, 5, 12, 13:   return "R5";
            6, 14:          return "R6";
            default:        return "R7";
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
        end
    endtask

    initial begin
        #2_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic held;
        rst = 1'b1; req_valid = 1'b1; req_code = 4'd8; {fn, fz, fv, fc} = 4'hF;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", res_valid, 1'b0, "valid in reset");
        check("R1", res_taken, 1'b0, "taken in reset");
        rst = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        check("R1", res_valid, 1'b0, "valid after reset");
        check("R1", res_taken, 1'b0, "taken after reset");

        // exhaustive sweep of flags and codes
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 16; k++) begin
                logic e;
                {fn, fz, fv, fc} = f[3:0];
                req_code  = k[3:0];
                req_valid = 1'b1;
                e = model(k, f[3], f[2], f[1], f[0]);
                @(negedge clk);
                got[f][k] = res_taken;
                check("R9", res_valid, 1'b1, $sformatf("valid code=%0d flags=%h", k, f));
                check(req_of(k), res_taken, e, $sformatf("code=%0d flags=%h", k, f));
            end
        end

        // R8 pairing of each code with its inverted partner
        for (int f = 0; f < 16; f++) begin
            for (int k = 0; k < 8; k++) begin
                check("R8", got[f][k+8], !got[f][k], $sformatf("pair %0d/%0d flags=%h", k, k + 8, f));
            end
        end

        // R10 idle cycles with changing inputs
        req_valid = 1'b1; req_code = 4'd8;
        @(negedge clk);
        held = res_taken;
        check("R9", held, 1'b1, "always before idle");
        for (int i = 0; i < 4; i++) begin
            req_valid = 1'b0;
            req_code = 4'(i);
            {fn, fz, fv, fc} = 4'(i * 5);
            @(negedge clk);
            check("R10", res_valid, 1'b0, "idle valid");
            check("R10", res_taken, held, "idle hold");
        end
        req_valid = 1'b1; req_code = 4'd0;
        @(negedge clk);
        check("R2", res_taken, 1'b0, "never after idle");
        req_valid = 1'b0;
        @(negedge clk);
        check("R10", res_taken, 1'b0, "idle hold low");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule